// File: doc/BRIEF.md
# Serial Line Receive Buffer Controller

This block takes a bursty serial bitstream, delivered as a data bit qualified by an active-low enable and clocked by a line strobe. The strobe is asynchronous to the system clock. The block groups the incoming bits into bytes and keeps those bytes in a circular queue held in an external byte-wide static RAM. It drives every pin of that RAM: the address, the write data, the write strobe, the chip select and the output enable. A downstream consumer takes bytes out of the queue one request at a time.

The controller reports two occupancy flags. One shows that the queue is empty. The other is a high-water mark at nine tenths of capacity, which is a warning and not an error. If a byte arrives while the queue is completely full, the controller discards the whole queue, raises the empty flag and holds its ready output low for a short recovery window. A clear input drops the contents of the queue on command. A hold input makes the controller accept line traffic and throw it away, so the queue does not grow while downstream processing is suspended.

Top module: `lrx_buf_ctrl`

## Requirements
- R1: While `rst_n` is low, `line_ready` is low, `buf_empty` is high, `buf_full` is low and `sram_we_n`, `sram_cs_n` and `sram_oe_n` are all high.
- R2: A bit is taken only on a rising edge of `line_clk` while `line_en_n` is low. Strobe edges with `line_en_n` high are ignored. Bits are packed most significant first, and every eighth bit completes a byte that is written to the RAM at the write pointer.
- R3: When `rd_req` is sampled high with the queue non-empty and no write pending, the oldest byte is read. `out_vld` is then high in the second cycle after that edge and `out_byte` carries the byte, so bytes come out in arrival order. A request made while the queue is empty produces no `out_vld`.
- R4: `buf_empty` is high exactly when the occupancy is zero.
- R5: `buf_full` is high when the occupancy is at least floor(9 x 2^AW / 10), and low below that. Reaching this mark is not an error: `line_ready` stays high.
- R6: A byte that completes while the occupancy equals 2^AW is not stored. Both pointers and the occupancy return to zero and `buf_empty` rises. `line_ready` goes low for OVF_HOLD cycles, and bytes that complete during that window are dropped.
- R7: A `clr` pulse resets both pointers, the occupancy and any partly received byte. The next stored byte goes to RAM address 0.
- R8: While `hold` is high, completed bytes are discarded and no RAM write occurs, so the occupancy does not change.
- R9: A read cycle and a write cycle never overlap. A pending write takes the RAM ahead of a read request.
- R10: A write cycle is one clock with `sram_cs_n` and `sram_we_n` low and `sram_oe_n` high. A read cycle is one clock with `sram_cs_n` and `sram_oe_n` low and `sram_we_n` high. Neither strobe is driven low without the chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_clk | input | 1 | Asynchronous line strobe; data is taken on its rising edge |
| line_en_n | input | 1 | Active-low qualifier for the line bit |
| line_dat | input | 1 | Serial line data bit |
| line_ready | output | 1 | High when line data can be accepted |
| hold | input | 1 | Discard incoming bytes while high |
| clr | input | 1 | Clear the queue and the partial byte |
| rd_req | input | 1 | Consumer request for one byte |
| out_vld | output | 1 | `out_byte` holds a byte read from the queue |
| out_byte | output | 8 | Byte delivered to the consumer |
| buf_full | output | 1 | Occupancy at or above the 90% mark |
| buf_empty | output | 1 | Occupancy is zero |
| sram_addr | output | AW (15) | RAM address |
| sram_wdata | output | 8 | RAM write data |
| sram_rdata | input | 8 | RAM read data |
| sram_we_n | output | 1 | Active-low RAM write strobe |
| sram_cs_n | output | 1 | Active-low RAM chip select |
| sram_oe_n | output | 1 | Active-low RAM output enable |

## Verification
Take the edge at which `line_clk` first reads high in the system domain. After it, the bit enters the byte at the third system edge. A completed byte becomes pending at the fourth edge and is written, with the occupancy updated, at the fifth. A discarded overflow byte also drops `line_ready` at the fifth edge. The bench holds each strobe phase for four clocks and samples the flags, the model RAM and `line_ready` only after the low phase has ended, which is at least eight edges after the rise. A read request is presented over exactly one edge, and `out_vld` and `out_byte` are sampled on the falling edge after the second rising edge. Reads are issued only when no line byte is in flight.

// File: rtl/lrx_pkg.sv
// Shared types for the serial line receive buffer controller.
package lrx_pkg;

    // One RAM operation, selected by the ring controller each cycle.
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_WR   = 2'd1,
        OP_RD   = 2'd2
    } sram_op_e;

    // High-water mark: nine tenths of the capacity, rounded down.
    function automatic int full_mark(input int depth);
        return (depth * 9) / 10;
    endfunction

endpackage

// File: rtl/lrx_line_in.sv
// Line input stage.
// Brings the asynchronous strobe, enable and data into the clk domain
// through SYNC_STAGES flops each. A rising strobe edge with the enable low
// shifts one bit into a byte, most significant bit first. The cycle after
// the eighth bit, byte_vld pulses for one clock.
// Assumes each strobe phase lasts at least SYNC_STAGES+1 clocks and that
// data and enable are stable around the rising edge of the strobe.
module lrx_line_in #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       line_clk,
    input  logic       line_en_n,
    input  logic       line_dat,
    output logic       byte_vld,
    output logic [7:0] byte_dat
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] s_clk, s_en_n, s_dat;
    logic         clk_prev;
    logic [6:0]   shreg;
    logic [2:0]   bit_cnt;
    logic         take;

    // Synchronizer chains for the three line signals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_clk    <= '0;
            s_en_n   <= '1;
            s_dat    <= '0;
            clk_prev <= 1'b0;
        end else begin
            s_clk    <= {s_clk[TOP-1:0], line_clk};
            s_en_n   <= {s_en_n[TOP-1:0], line_en_n};
            s_dat    <= {s_dat[TOP-1:0], line_dat};
            clk_prev <= s_clk[TOP];
        end
    end

    // A qualified rising edge of the synchronized strobe.
    always_comb take = s_clk[TOP] && !clk_prev && !s_en_n[TOP];

    // Shift bits in MSB first and emit each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            byte_vld <= 1'b0;
            byte_dat <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (take) begin
                shreg   <= {shreg[5:0], s_dat[TOP]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_vld <= 1'b1;
                    byte_dat <= {shreg, s_dat[TOP]};
                end
            end
        end
    end

endmodule

// File: rtl/lrx_ring.sv
// Circular queue control.
// Owns the read and write pointers and the occupancy count, and picks the
// RAM operation for each cycle. A pending write comes before a read. A write
// into a completely full queue empties the queue instead and closes the
// line input for OVF_HOLD cycles. A clear always wins.
// Assumes byte_vld pulses are at least two cycles apart.
module lrx_ring #(
    parameter int AW       = 15,
    parameter int OVF_HOLD = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  hold,
    input  logic                  byte_vld,
    input  logic [7:0]            byte_dat,
    input  logic                  rd_req,
    output lrx_pkg::sram_op_e     op,
    output logic [AW-1:0]         op_addr,
    output logic [7:0]            op_data,
    output logic                  buf_empty,
    output logic                  buf_full,
    output logic                  line_ready
);
    import lrx_pkg::*;

    localparam int CW      = AW + 1;
    localparam int DEPTH   = 1 << AW;
    localparam int FULL_TH = full_mark(DEPTH);
    localparam int HW      = $clog2(OVF_HOLD + 1);

    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] occ;
    logic          wr_pend;
    logic [7:0]    wr_byte;
    logic          ready_q;
    logic [HW-1:0] ovf_cnt;
    logic          ovf;
    logic          accept;

    // Choose this cycle's RAM operation and detect overflow.
    always_comb begin
        ovf     = wr_pend && (occ == CW'(DEPTH)) && !clr;
        accept  = byte_vld && !hold && ready_q && !clr;
        op      = OP_IDLE;
        op_addr = '0;
        op_data = wr_byte;
        if (!clr) begin
            if (wr_pend && !ovf) begin
                op      = OP_WR;
                op_addr = wptr;
            end else if (!wr_pend && rd_req && occ != '0) begin
                op      = OP_RD;
                op_addr = rptr;
            end
        end
    end

    // Update the pointers, the occupancy and the pending-write slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr    <= '0;
            rptr    <= '0;
            occ     <= '0;
            wr_pend <= 1'b0;
            wr_byte <= '0;
        end else begin
            wr_pend <= accept;
            if (accept) wr_byte <= byte_dat;
            if (ovf) begin
                wptr <= '0;
                rptr <= '0;
                occ  <= '0;
            end else if (op == OP_WR) begin
                wptr <= wptr + 1'b1;
                occ  <= occ + 1'b1;
            end else if (op == OP_RD) begin
                rptr <= rptr + 1'b1;
                occ  <= occ - 1'b1;
            end
        end
    end

    // Line ready: low in reset and during the window after an overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            ovf_cnt <= '0;
        end else if (ovf) begin
            ready_q <= 1'b0;
            ovf_cnt <= HW'(OVF_HOLD);
        end else if (ovf_cnt != '0) begin
            ovf_cnt <= ovf_cnt - 1'b1;
            ready_q <= (ovf_cnt == HW'(1));
        end else begin
            ready_q <= 1'b1;
        end
    end

    // Occupancy flags.
    always_comb begin
        buf_empty  = (occ == '0);
        buf_full   = (occ >= CW'(FULL_TH));
        line_ready = ready_q;
    end

endmodule

// File: rtl/lrx_sram_if.sv
// RAM pin sequencer.
// Registers the chosen operation onto the RAM pins as a one-clock cycle:
// a write lowers chip select and write strobe, and a read lowers chip select
// and output enable. Read data is captured at the edge that ends the read
// cycle, and out_vld then pulses for one clock.
// Assumes an asynchronous RAM whose read data settles within one clock.
module lrx_sram_if #(
    parameter int AW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lrx_pkg::sram_op_e op,
    input  logic [AW-1:0]     op_addr,
    input  logic [7:0]        op_data,
    input  logic [7:0]        sram_rdata,
    output logic [AW-1:0]     sram_addr,
    output logic [7:0]        sram_wdata,
    output logic              sram_we_n,
    output logic              sram_cs_n,
    output logic              sram_oe_n,
    output logic              out_vld,
    output logic [7:0]        out_byte
);
    import lrx_pkg::*;

    // Drive the RAM pins for the next clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr  <= '0;
            sram_wdata <= '0;
            sram_we_n  <= 1'b1;
            sram_cs_n  <= 1'b1;
            sram_oe_n  <= 1'b1;
        end else begin
            sram_addr  <= op_addr;
            sram_wdata <= op_data;
            sram_we_n  <= (op != OP_WR);
            sram_oe_n  <= (op != OP_RD);
            sram_cs_n  <= (op == OP_IDLE);
        end
    end

    // Capture the read data at the end of a read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_byte <= '0;
        end else begin
            out_vld <= !sram_oe_n && !sram_cs_n;
            if (!sram_oe_n && !sram_cs_n) out_byte <= sram_rdata;
        end
    end

endmodule

// File: rtl/lrx_buf_ctrl.sv
// Serial line receive buffer controller, top level.
// Line input stage -> circular queue control -> RAM pin sequencer.
// Assumes one external asynchronous RAM of 2^AW bytes that is used only by
// this block.
module lrx_buf_ctrl #(
    parameter int AW          = 15,
    parameter int SYNC_STAGES = 2,
    parameter int OVF_HOLD    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_clk,
    input  logic          line_en_n,
    input  logic          line_dat,
    output logic          line_ready,
    input  logic          hold,
    input  logic          clr,
    input  logic          rd_req,
    output logic          out_vld,
    output logic [7:0]    out_byte,
    output logic          buf_full,
    output logic          buf_empty,
    output logic [AW-1:0] sram_addr,
    output logic [7:0]    sram_wdata,
    input  logic [7:0]    sram_rdata,
    output logic          sram_we_n,
    output logic          sram_cs_n,
    output logic          sram_oe_n
);
    logic              byte_vld;
    logic [7:0]        byte_dat;
    lrx_pkg::sram_op_e op;
    logic [AW-1:0]     op_addr;
    logic [7:0]        op_data;

    lrx_line_in #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .flush(clr),
        .line_clk(line_clk), .line_en_n(line_en_n), .line_dat(line_dat),
        .byte_vld(byte_vld), .byte_dat(byte_dat)
    );

    lrx_ring #(.AW(AW), .OVF_HOLD(OVF_HOLD)) u_ring (
        .clk(clk), .rst_n(rst_n), .clr(clr), .hold(hold),
        .byte_vld(byte_vld), .byte_dat(byte_dat), .rd_req(rd_req),
        .op(op), .op_addr(op_addr), .op_data(op_data),
        .buf_empty(buf_empty), .buf_full(buf_full), .line_ready(line_ready)
    );

    lrx_sram_if #(.AW(AW)) u_sram (
        .clk(clk), .rst_n(rst_n), .op(op), .op_addr(op_addr),
        .op_data(op_data), .sram_rdata(sram_rdata),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata),
        .sram_we_n(sram_we_n), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
        .out_vld(out_vld), .out_byte(out_byte)
    );

endmodule

// File: rtl/lrx_buf_ctrl_chk.sv
// Property checker for lrx_buf_ctrl. It sees only the ports of the top
// module and is attached to it by the bind below.
module lrx_buf_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic clr,
    input logic line_ready,
    input logic buf_empty,
    input logic buf_full,
    input logic out_vld,
    input logic sram_we_n,
    input logic sram_cs_n,
    input logic sram_oe_n
);
    // R1: the line is not ready in the cycle after a reset edge.
    p_rst_not_ready_r1: assert property (@(posedge clk)
        !rst_n |=> !line_ready);

    // R3: read data is presented only after a read cycle on the pins.
    p_rd_after_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(!sram_oe_n && !sram_cs_n));

    // R5: the full mark and the empty flag are never high together.
    p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_empty && buf_full));

    // R6: the ready output falls only together with an emptied queue.
    p_ovf_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_ready) |-> buf_empty);

    // R7: a clear leaves the queue empty.
    p_clr_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> buf_empty);

    // R9: read and write strobes never overlap.
    p_no_rw_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n));

    // R10: a strobe is only driven with the chip selected.
    p_strobe_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n || !sram_oe_n) |-> !sram_cs_n);

endmodule

bind lrx_buf_ctrl lrx_buf_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .line_ready(line_ready),
    .buf_empty(buf_empty), .buf_full(buf_full), .out_vld(out_vld),
    .sram_we_n(sram_we_n), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n)
);

// File: tb/lrx_buf_ctrl_tb.sv
// Bench for lrx_buf_ctrl with a small ring (AW=6, 64 bytes, full mark 57).
module lrx_buf_ctrl_tb;
    localparam int AW      = 6;
    localparam int DEPTH   = 1 << AW;
    localparam int FULL_TH = (DEPTH * 9) / 10;
    localparam int OVF_HOLD = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_clk = 1'b0, line_en_n = 1'b1, line_dat = 1'b0;
    logic hold = 1'b0, clr = 1'b0, rd_req = 1'b0;
    logic line_ready, out_vld, buf_full, buf_empty;
    logic [7:0] out_byte, sram_wdata, sram_rdata;
    logic [AW-1:0] sram_addr;
    logic sram_we_n, sram_cs_n, sram_oe_n;

    int checks = 0;
    int fails = 0;
    int wr_seen = 0;
    int pin_viol = 0;
    logic [7:0] tb_mem [DEPTH];
    logic [7:0] model_q [$];
    bit model_hold = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    lrx_buf_ctrl #(.AW(AW), .SYNC_STAGES(2), .OVF_HOLD(OVF_HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .line_en_n(line_en_n),
        .line_dat(line_dat), .line_ready(line_ready), .hold(hold), .clr(clr),
        .rd_req(rd_req), .out_vld(out_vld), .out_byte(out_byte),
        .buf_full(buf_full), .buf_empty(buf_empty), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .sram_we_n(sram_we_n), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n)
    );

    // Asynchronous RAM model and pin-protocol monitor (R9, R10).
    assign sram_rdata = (!sram_cs_n && !sram_oe_n) ? tb_mem[sram_addr] : 8'h00;
    always @(posedge clk) begin
        if (!sram_cs_n && !sram_we_n) begin
            tb_mem[sram_addr] <= sram_wdata;
            wr_seen <= wr_seen + 1;
        end
        if (rst_n && ((!sram_we_n && !sram_oe_n) ||
                      ((!sram_we_n || !sram_oe_n) && sram_cs_n)))
            pin_viol <= pin_viol + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // One strobe period: 4 clocks high, 4 low, enable set before the rise.
    task automatic send_bit(input logic b, input logic en);
        @(negedge clk); line_dat = b; line_en_n = !en;
        @(negedge clk); line_clk = 1'b1;
        repeat (4) @(negedge clk);
        line_clk = 1'b0;
        repeat (4) @(negedge clk);
        line_en_n = 1'b1;
    endtask

    // Expected effect of one completed byte on the queue model.
    function automatic bit model_accept(input logic [7:0] b);
        if (model_hold) return 1'b0;
        if (model_q.size() == DEPTH) begin
            model_q.delete();
            return 1'b1;
        end
        model_q.push_back(b);
        return 1'b0;
    endfunction

    // Send a byte MSB first, with optional ignored (enable high) strobes.
    task automatic send_byte(input logic [7:0] b, input bit noise, output bit ovf);
        for (int i = 7; i >= 0; i--) begin
            if (noise && ($urandom % 3 == 0)) send_bit(1'($urandom), 1'b0);
            send_bit(b[i], 1'b1);
        end
        ovf = model_accept(b);
    endtask

    // One request over one edge; data is due after the second edge.
    task automatic read_one(input string req);
        logic [7:0] exp;
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        @(negedge clk);
        exp = model_q.pop_front();
        check({req, " out_vld"}, int'(out_vld), 1);
        check({req, " out_byte"}, int'(out_byte), int'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        bit ovf;
        int base;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) tb_mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 line_ready", int'(line_ready), 0);
        check("R1 buf_empty", int'(buf_empty), 1);
        check("R1 buf_full", int'(buf_full), 0);
        check("R1 strobes", int'({sram_we_n, sram_cs_n, sram_oe_n}), 7);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 ready after reset", int'(line_ready), 1);

        // R2: first byte lands at address 0, ignored strobes mixed in
        send_byte(8'hA5, 1'b1, ovf);
        check("R2 mem[0]", int'(tb_mem[0]), 8'hA5);
        check("R4 not empty", int'(buf_empty), 0);

        // R3: random bytes read back in order
        for (int k = 0; k < 20; k++) send_byte(8'($urandom), 1'b1, ovf);
        check("R5 below mark", int'(buf_full), 0);
        while (model_q.size() != 0) read_one("R3");
        check("R4 empty after drain", int'(buf_empty), 1);

        // R3: request on an empty queue produces nothing
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        @(negedge clk);
        check("R3 empty read no out_vld", int'(out_vld), 0);

        // R7: clear drops stored and partial data, pointers restart at 0
        for (int k = 0; k < 3; k++) send_byte(8'($urandom), 1'b0, ovf);
        for (int k = 0; k < 3; k++) send_bit(1'b1, 1'b1);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        model_q.delete();
        check("R7 empty after clr", int'(buf_empty), 1);
        send_byte(8'h3C, 1'b0, ovf);
        check("R7 mem[0] after clr", int'(tb_mem[0]), 8'h3C);
        read_one("R7");

        // R8: hold discards bytes
        base = wr_seen;
        hold = 1'b1; model_hold = 1'b1;
        send_byte(8'h11, 1'b0, ovf);
        send_byte(8'h22, 1'b1, ovf);
        hold = 1'b0; model_hold = 1'b0;
        check("R8 no writes in hold", wr_seen - base, 0);
        check("R8 still empty", int'(buf_empty), 1);

        // R5: fill across the 90% mark
        for (int k = 1; k <= DEPTH; k++) begin
            send_byte(8'(k * 3), 1'b0, ovf);
            if (k == FULL_TH - 1) check("R5 full below mark", int'(buf_full), 0);
            if (k == FULL_TH) begin
                check("R5 full at mark", int'(buf_full), 1);
                check("R5 ready at mark", int'(line_ready), 1);
            end
        end
        check("R5 full at capacity", int'(buf_full), 1);

        // R6: one more byte overflows
        send_byte(8'hEE, 1'b0, ovf);
        check("R6 model overflow", int'(ovf), 1);
        check("R6 empty after overflow", int'(buf_empty), 1);
        check("R6 ready low", int'(line_ready), 0);
        check("R6 full low", int'(buf_full), 0);
        repeat (OVF_HOLD + 4) @(negedge clk);
        check("R6 ready restored", int'(line_ready), 1);
        send_byte(8'h81, 1'b1, ovf);
        check("R6 mem[0] after overflow", int'(tb_mem[0]), 8'h81);
        read_one("R6");

        // R9, R10: pin protocol held throughout
        check("R9 R10 pin violations", pin_viol, 0);
        report();
    end

endmodule